// File: doc/BRIEF.md
# TMDS Clock Lane Pattern Generator

This block supplies the parallel 10-bit characters for the clock lane of a TMDS transmitter. Software programs two 32-bit staging registers, each carrying two 10-bit pattern words. Together they hold a four-word cycle. On every asserted character enable, the generator emits one word, in the order word 0, 1, 2, 3 and then word 0 again. A serializer downstream turns each word into bits; that serializer lies outside this block.

The staged words do not affect the lane directly. A load command copies them into active shadow registers and silences the output. A later start command resumes output from word 0. Because of this, one engine covers two cases: the ordinary clock, where every character holds five ones and five zeros, and the quarter-rate clock used at high bit rates, where twenty zeros are followed by twenty ones. The block also enforces the settling delay required between load and start with a cycle counter, so a start issued too early has no effect.

Top module: `tmds_clk_patgen`

## Requirements
- R1: After reset, `sym_out` is 0x000, and it stays 0x000 for any activity on `char_en` until a start command has been accepted.
- R2: Address 0 stages pattern words 0 and 1, and address 1 stages words 2 and 3. In each of these registers the even word sits in bits [9:0] and the odd word in bits [25:16]. All other data bits are ignored.
- R3: Writing any value other than 0x1 or 0x2 to the control address (address 2) has no effect on the output sequence.
- R4: Writes to the staging registers while output is running do not change the emitted words until the next load command.
- R5: Writing 0x1 to the control address copies all four staged words into the shadow registers and arms a start. From the next cycle, `sym_out` is 0x000 and `char_en` is ignored.
- R6: Writing 0x2 to the control address is accepted only if a load has armed it and at least `GAP_CYC` cycles have passed since that load. Otherwise the write is ignored. An accepted start clears the arm.
- R7: After an accepted start, successive asserted `char_en` cycles present shadow words 0, 1, 2, 3, 0, ... on `sym_out`, one cycle after each enable.
- R8: While output is running, `sym_out` holds its value in any cycle where `char_en` is low.
- R9: Staging 0x001F001F in both registers gives the word 0x01F on every character (the normal 1:10 clock).
- R10: Staging 0x00000000 at address 0 and 0x03FF03FF at address 1 gives 0x000, 0x000, 0x3FF, 0x3FF (the 1:40 clock).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock domain clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address: 0 and 1 are pattern staging, 2 is control |
| wr_data | input | DATA_W | Register write data |
| char_en | input | 1 | Character enable; advances the pattern |
| sym_out | output | SYM_W | Registered 10-bit clock-lane character |

## Verification
The bench builds the block with `GAP_CYC` set to 16 rather than the default of 2,000,000 cycles (20 ms at 100 MHz). With that setting, both an early start that must be rejected and a later start that must be accepted fit within a few dozen cycles. All other parameters keep their defaults. This lets the field placement at bits [9:0] and [25:16], and the four-word wrap, be checked exactly as they are deployed.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  // register map of the generator
  localparam int unsigned WORDS_PER_REG = 2;
  localparam logic [31:0] CMD_LOAD  = 32'h0000_0001;
  localparam logic [31:0] CMD_START = 32'h0000_0002;

  typedef enum logic [1:0] {
    ADR_PAT_A = 2'd0,
    ADR_PAT_B = 2'd1,
    ADR_CTRL  = 2'd2
  } tcp_adr_e;
endpackage

// File: rtl/tcp_stage.sv
module tcp_stage #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned SYM_W     = 10,
  parameter int unsigned HI_LSB    = 16,
  parameter int unsigned NUM_WORDS = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [NUM_WORDS-1:0][SYM_W-1:0] stage_words
);
  localparam int unsigned NUM_REGS = NUM_WORDS / tcp_pkg::WORDS_PER_REG;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_words[2*g]   <= '0;
        stage_words[2*g+1] <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
        stage_words[2*g]   <= wr_data[SYM_W-1:0];
        stage_words[2*g+1] <= wr_data[HI_LSB +: SYM_W];
      end
    end
  end
endmodule

// File: rtl/tcp_ctrl.sv
module tcp_ctrl #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned CTRL_ADDR = 2,
  parameter int unsigned GAP_CYC   = 2000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              load_go,
  output logic              start_go
);
  localparam int unsigned GW = $clog2(GAP_CYC + 2);

  logic          ctrl_wr;
  logic          armed_q;
  logic [GW-1:0] gap_q;

  assign ctrl_wr  = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  assign load_go  = ctrl_wr && (wr_data == DATA_W'(tcp_pkg::CMD_LOAD));
  assign start_go = ctrl_wr && (wr_data == DATA_W'(tcp_pkg::CMD_START))
                    && armed_q && (gap_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      gap_q   <= '0;
    end else begin
      if (load_go) begin
        armed_q <= 1'b1;
        gap_q   <= GW'(GAP_CYC);
      end else begin
        if (start_go)      armed_q <= 1'b0;
        if (gap_q != '0)   gap_q   <= gap_q - 1'b1;
      end
    end
  end

  // R3: unknown command values leave the arm untouched
  a_r3_ignore_cmd: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !load_go && (wr_data != DATA_W'(tcp_pkg::CMD_START)))
      |=> $stable(armed_q));
  // R6: an accepted start consumes the arm
  a_r6_arm_consumed: assert property (@(posedge clk) disable iff (rst)
    start_go |=> !armed_q);
  // R6: the settle window counts down one per cycle
  a_r6_gap_count: assert property (@(posedge clk) disable iff (rst)
    (!load_go && gap_q != '0) |=> (gap_q == $past(gap_q) - 1'b1));
endmodule

// File: rtl/tcp_seq.sv
module tcp_seq #(
  parameter int unsigned SYM_W     = 10,
  parameter int unsigned NUM_WORDS = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            load_go,
  input  logic                            start_go,
  input  logic                            char_en,
  input  logic [NUM_WORDS-1:0][SYM_W-1:0] stage_words,
  output logic [SYM_W-1:0]                sym_q
);
  localparam int unsigned IDX_W = $clog2(NUM_WORDS);

  logic [SYM_W-1:0] shadow_q [NUM_WORDS];
  logic             run_q;
  logic [IDX_W-1:0] idx_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (rst)          shadow_q[w] <= '0;
      else if (load_go) shadow_q[w] <= stage_words[w];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      idx_q <= '0;
      sym_q <= '0;
    end else if (load_go) begin
      run_q <= 1'b0;
      sym_q <= '0;
    end else if (start_go) begin
      run_q <= 1'b1;
      idx_q <= '0;
    end else if (run_q && char_en) begin
      sym_q <= shadow_q[idx_q];
      idx_q <= (idx_q == IDX_W'(NUM_WORDS - 1)) ? '0 : idx_q + 1'b1;
    end
  end

  // R1: a stopped engine drives all zeros
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> (sym_q == '0));
  // R5: load silences output
  a_r5_load_stop: assert property (@(posedge clk) disable iff (rst)
    load_go |=> (!run_q && sym_q == '0));
  // R6: accepted start begins at word 0
  a_r6_restart: assert property (@(posedge clk) disable iff (rst)
    start_go |=> (run_q && idx_q == '0));
  // R7: the word index advances with wrap
  a_r7_step: assert property (@(posedge clk) disable iff (rst)
    (run_q && char_en && !load_go && !start_go) |=>
      (idx_q == (($past(idx_q) == IDX_W'(NUM_WORDS - 1)) ? '0 : $past(idx_q) + 1'b1)));
  // R8: no enable, no change
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!char_en && !load_go) |=> $stable(sym_q));
endmodule

// File: rtl/tmds_clk_patgen.sv
module tmds_clk_patgen #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned SYM_W     = 10,
  parameter int unsigned HI_LSB    = 16,
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned GAP_CYC   = 2000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              char_en,
  output logic [SYM_W-1:0]  sym_out
);
  localparam int unsigned CTRL_ADDR = NUM_WORDS / tcp_pkg::WORDS_PER_REG;

  logic [NUM_WORDS-1:0][SYM_W-1:0] stage_words;
  logic                            load_go;
  logic                            start_go;

  tcp_stage #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYM_W(SYM_W),
    .HI_LSB(HI_LSB), .NUM_WORDS(NUM_WORDS)
  ) u_stage (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .stage_words(stage_words)
  );

  tcp_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .GAP_CYC(GAP_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_go(load_go), .start_go(start_go)
  );

  tcp_seq #(
    .SYM_W(SYM_W), .NUM_WORDS(NUM_WORDS)
  ) u_seq (
    .clk(clk), .rst(rst), .load_go(load_go), .start_go(start_go),
    .char_en(char_en), .stage_words(stage_words), .sym_q(sym_out)
  );

  // R4: a staging write alone never disturbs the lane while stopped
  a_r4_stage_isolated: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != ADDR_W'(CTRL_ADDR) && !char_en) |=> $stable(sym_out));
endmodule

// File: tb/tb_tmds_clk_patgen.sv
module tb_tmds_clk_patgen;
  localparam int unsigned GAP = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        char_en = 1'b0;
  logic [9:0]  sym_out;

  int checks = 0;
  int errors = 0;

  tmds_clk_patgen #(.GAP_CYC(GAP)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .char_en(char_en), .sym_out(sym_out)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%03h expected=0x%03h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input string req, input logic [9:0] exp);
    char_en = 1'b1;
    @(negedge clk);
    char_en = 1'b0;
    chk(req, sym_out, exp);
  endtask

  task automatic load_and_start();
    wr(2'd2, 32'h1);
    repeat (GAP + 2) @(negedge clk);
    wr(2'd2, 32'h2);
  endtask

  task automatic t_reset();
    chk("R1 reset", sym_out, 10'h000);
    for (int i = 0; i < 3; i++) step("R1 no start yet", 10'h000);
  endtask

  task automatic t_start_unarmed();
    wr(2'd2, 32'h2);
    for (int i = 0; i < 2; i++) step("R6 start without load", 10'h000);
  endtask

  task automatic t_fields_and_order();
    wr(2'd0, (32'h3F << 26) | (32'h2AA << 16) | (32'h3F << 10) | 32'h155);
    wr(2'd1, (32'h3F << 26) | (32'h0F0 << 16) | (32'h3F << 10) | 32'h30F);
    wr(2'd2, 32'h1);
    wr(2'd2, 32'h2);  // too early
    step("R6 early start ignored", 10'h000);
    repeat (GAP + 2) @(negedge clk);
    wr(2'd2, 32'h2);
    step("R2 R7 word0", 10'h155);
    step("R2 R7 word1", 10'h2AA);
    step("R2 R7 word2", 10'h30F);
    step("R2 R7 word3", 10'h0F0);
    step("R7 wrap", 10'h155);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 hold", sym_out, 10'h155);
    end
    step("R8 resume", 10'h2AA);
  endtask

  task automatic t_stage_while_running();
    wr(2'd0, 32'h0111_0222);
    wr(2'd1, 32'h0333_0044);
    step("R4 unchanged w2", 10'h30F);
    step("R4 unchanged w3", 10'h0F0);
  endtask

  task automatic t_bad_cmd();
    wr(2'd2, 32'h3);
    step("R3 cmd 3 ignored", 10'h155);
    wr(2'd2, 32'h0);
    step("R3 cmd 0 ignored", 10'h2AA);
    wr(2'd2, 32'h2);  // unarmed after accepted start
    step("R6 second start ignored", 10'h30F);
  endtask

  task automatic t_load_stops();
    wr(2'd2, 32'h1);
    chk("R5 load silences", sym_out, 10'h000);
    step("R5 char_en ignored", 10'h000);
    repeat (GAP + 2) @(negedge clk);
    wr(2'd2, 32'h2);
    step("R4 R5 new word0", 10'h222);
    step("R4 R5 new word1", 10'h111);
    step("R4 R5 new word2", 10'h044);
    step("R4 R5 new word3", 10'h333);
  endtask

  task automatic t_normal_ratio();
    wr(2'd0, 32'h001F001F);
    wr(2'd1, 32'h001F001F);
    load_and_start();
    for (int i = 0; i < 5; i++) step("R9 normal clock", 10'h01F);
  endtask

  task automatic t_high_ratio();
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h03FF03FF);
    load_and_start();
    step("R10 w0", 10'h000);
    step("R10 w1", 10'h000);
    step("R10 w2", 10'h3FF);
    step("R10 w3", 10'h3FF);
    step("R10 wrap", 10'h000);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_start_unarmed();
    t_fields_and_order();
    t_hold();
    t_stage_while_running();
    t_bad_cmd();
    t_load_stops();
    t_normal_ratio();
    t_high_ratio();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule